// File: doc/BRIEF.md
# MAC Receive Control-Frame Filter

This block sits in the receive path of a full-duplex Ethernet MAC, after the CRC checker. It receives a byte stream with start and end markers and a CRC-good flag that is valid on the last byte. From the destination address and the length/type field it tells whether a frame is a MAC control frame. It then applies two mode bits to decide what happens to the frame. Pass-all lets control frames into the host receive buffer. Receive-flow lets a valid PAUSE frame become a pause request to the transmitter.

Each frame produces one decision, one cycle after its last byte. Either a buffer-descriptor status word is written, or the frame is dropped and the descriptor keeps its old value, or the frame is consumed as a flow-control event. Two sticky interrupt flags report stored frames and consumed control frames. The host clears a flag by writing a 1 to it.

Top module: `rxctl_filter`

## Requirements
- R1: A frame is a control frame when bytes 0..5 are 01 80 C2 00 00 01 and bytes 12..13 are 88 08. Any mismatch in those positions makes it an ordinary frame.
- R2: With pass_all=0 and rx_flow=0, a control frame is dropped. desc_wr stays low, desc_out takes the unchanged desc_in word, no flag is set and no pause request is issued.
- R3: With rx_flow=1, a valid PAUSE frame is consumed whatever pass_all is. A valid PAUSE frame is a control frame whose bytes 14..15 are 00 01 and whose CRC is good. It is not stored, and only flag bit 1 (control received) is set.
- R4: pause_req pulses for exactly one cycle, one cycle after the last byte, only for a consumed PAUSE frame. pause_quanta then carries bytes 16 (high) and 17 (low).
- R5: A frame that is not consumed is stored when it is not a control frame or when pass_all=1. It pulses desc_wr and sets flag bit 0 (buffer received) when desc_in bit 14 (interrupt enable) is 1.
- R6: A stored descriptor word holds the frame length including the CRC in bits 31:16. Bit 15 (empty) is 0, bits 14:13 are copied from desc_in, bit 8 marks a control frame, bit 1 marks a bad CRC, and all other bits are 0. A 64-byte PAUSE frame with desc_in 0x0000E000 gives 0x00406100.
- R7: A control frame with a bad CRC or an opcode other than 00 01 never produces a pause request. It is stored or dropped by the pass_all rule alone.
- R8: The flags hold until the host writes 1 to the matching irq_clear bit. irq_out is high exactly when a flag is set.
- R9: After reset, pause_req, desc_wr, desc_out, flags and irq_out are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_all | input | 1 | Store control frames in the receive buffer |
| rx_flow | input | 1 | Act on PAUSE frames |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_crc_ok | input | 1 | CRC good, valid with in_eof |
| desc_in | input | 32 | Current descriptor word |
| irq_clear | input | 2 | Write-1-to-clear for the flags |
| pause_req | output | 1 | One-cycle pause request |
| pause_quanta | output | 16 | Pause time from the frame |
| desc_wr | output | 1 | Descriptor write strobe (frame stored) |
| desc_out | output | 32 | Resulting descriptor word |
| flags | output | 2 | Bit 0 buffer received, bit 1 control received |
| irq_out | output | 1 | Host interrupt |

## Verification
The bench runs every mode pair against a correct PAUSE frame, PAUSE frames with a bad CRC, a control frame with a wrong opcode and a frame whose address differs only in its last byte. It toggles the descriptor's interrupt-enable bit and varies the frame length. A design that checked only the type field would take the near-miss address frame as a control frame and drop it. A design that ignored the CRC or the opcode would issue pause requests for corrupt frames. A design that let pass_all override rx_flow would store a consumed PAUSE frame and raise both flags. The bench also watches that the flags survive idle cycles and clear only on request.

// File: rtl/rxctl_filter.sv
module rxctl_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pass_all,
  input  logic        rx_flow,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  input  logic        in_crc_ok,
  input  logic [31:0] desc_in,
  input  logic [1:0]  irq_clear,
  output logic        pause_req,
  output logic [15:0] pause_quanta,
  output logic        desc_wr,
  output logic [31:0] desc_out,
  output logic [1:0]  flags,
  output logic        irq_out
);
  logic [15:0] cnt, idx, len_now, quanta_q, quanta_nx;
  logic        hdr_ok, op_ok, hdr_nx, op_nx;
  logic [7:0]  want;
  logic        chk_hdr, chk_op;
  logic        last, is_ctl, is_pz, take, keep;
  logic [31:0] desc_nx;

  assign idx     = in_sof ? 16'd0 : cnt;
  assign len_now = (&idx) ? idx : idx + 16'd1;

  always_comb begin
    want = 8'h00;
    chk_hdr = 1'b0;
    chk_op = 1'b0;
    if (idx < 16'd16) begin
      case (idx[3:0])
        4'd0:  begin want = 8'h01; chk_hdr = 1'b1; end
        4'd1:  begin want = 8'h80; chk_hdr = 1'b1; end
        4'd2:  begin want = 8'hC2; chk_hdr = 1'b1; end
        4'd3:  begin want = 8'h00; chk_hdr = 1'b1; end
        4'd4:  begin want = 8'h00; chk_hdr = 1'b1; end
        4'd5:  begin want = 8'h01; chk_hdr = 1'b1; end
        4'd12: begin want = 8'h88; chk_hdr = 1'b1; end
        4'd13: begin want = 8'h08; chk_hdr = 1'b1; end
        4'd14: begin want = 8'h00; chk_op = 1'b1; end
        4'd15: begin want = 8'h01; chk_op = 1'b1; end
        default: ;
      endcase
    end
  end

  assign hdr_nx = (in_sof | hdr_ok) & (~chk_hdr | (in_data == want));
  assign op_nx  = (in_sof | op_ok)  & (~chk_op  | (in_data == want));

  always_comb begin
    quanta_nx = quanta_q;
    if (idx == 16'd16) quanta_nx[15:8] = in_data;
    if (idx == 16'd17) quanta_nx[7:0]  = in_data;
  end

  assign last    = in_valid & in_eof;
  assign is_ctl  = hdr_nx & (len_now > 16'd13);
  assign is_pz   = is_ctl & op_nx & (len_now > 16'd17) & in_crc_ok;
  assign take    = rx_flow & is_pz;
  assign keep    = ~take & (~is_ctl | pass_all);
  assign desc_nx = {len_now, 1'b0, desc_in[14:13], 4'b0, is_ctl, 6'b0, ~in_crc_ok, 1'b0};
  assign irq_out = |flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      hdr_ok <= 1'b0;
      op_ok <= 1'b0;
      quanta_q <= '0;
      pause_req <= 1'b0;
      pause_quanta <= '0;
      desc_wr <= 1'b0;
      desc_out <= '0;
      flags <= '0;
    end else begin
      pause_req <= 1'b0;
      desc_wr <= 1'b0;
      if (in_valid) begin
        cnt <= len_now;
        hdr_ok <= hdr_nx;
        op_ok <= op_nx;
        quanta_q <= quanta_nx;
      end
      if (last) begin
        pause_req <= take;
        if (take) pause_quanta <= quanta_nx;
        desc_wr <= keep;
        desc_out <= keep ? desc_nx : desc_in;
      end
      flags <= (flags & ~irq_clear) | {last & take, last & keep & desc_in[14]};
    end
  end

  a_r4_pause_needs_flow: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> $past(rx_flow));
  a_r3_consumed_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |-> !desc_wr);
  a_r3_ctl_flag_with_pause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> pause_req);
  a_r6_stored_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wr |-> !desc_out[15]);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !irq_clear[0]) |=> flags[0]);
endmodule

// File: tb/rxctl_filter_test.sv
`timescale 1ns/1ps
module rxctl_filter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pass_all = 1'b0, rx_flow = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_crc_ok = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [31:0] desc_in = 32'h0;
  logic [1:0] irq_clear = 2'b00;
  logic pause_req, desc_wr, irq_out;
  logic [15:0] pause_quanta;
  logic [31:0] desc_out;
  logic [1:0] flags;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rxctl_filter uut (.clk(clk), .rst_n(rst_n), .pass_all(pass_all), .rx_flow(rx_flow),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_crc_ok(in_crc_ok), .desc_in(desc_in), .irq_clear(irq_clear),
    .pause_req(pause_req), .pause_quanta(pause_quanta), .desc_wr(desc_wr),
    .desc_out(desc_out), .flags(flags), .irq_out(irq_out));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // kind 0: PAUSE, 1: control with opcode 2, 2: ordinary, 3: address near miss
  function automatic logic [7:0] byte_at(int kind, int i, logic [15:0] q);
    logic [7:0] da [6];
    da = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
    if (i < 6) begin
      if (kind == 2) return 8'h20 + 8'(i);
      if (kind == 3 && i == 5) return 8'h02;
      return da[i];
    end
    if (i < 12) return 8'h10 + 8'(i);
    if (i == 12) return (kind == 2) ? 8'h08 : 8'h88;
    if (i == 13) return (kind == 2) ? 8'h00 : 8'h08;
    if (i == 14) return 8'h00;
    if (i == 15) return (kind == 1) ? 8'h02 : 8'h01;
    if (i == 16) return q[15:8];
    if (i == 17) return q[7:0];
    return 8'(i * 3);
  endfunction

  task automatic run_frame(int kind, bit crc, int len, logic [15:0] q, bit ie);
    bit ctl, take, keep;
    logic [31:0] dexp;
    desc_in = {16'h0, 1'b1, ie, 1'b1, 13'h0};
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = byte_at(kind, i, q); in_crc_ok = crc;
    end
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    ctl  = (kind <= 1);
    take = rx_flow && kind == 0 && crc;
    keep = !take && (!ctl || pass_all);
    dexp = keep ? {16'(len), 1'b0, 1'b1, 1'b1, 4'b0, ctl, 6'b0, !crc, 1'b0} & ~(32'(!ie) << 14) : desc_in;
    chk(pause_req == take, take ? "R3/R4 pause consumed" : "R7 no pause", 32'(pause_req), 32'(take));
    if (take) chk(pause_quanta == q, "R4 quanta", 32'(pause_quanta), 32'(q));
    chk(desc_wr == keep, keep ? "R5 stored" : "R2 dropped", 32'(desc_wr), 32'(keep));
    chk(desc_out == dexp, keep ? "R6 descriptor" : "R2 descriptor kept", desc_out, dexp);
    chk(flags == {take, keep && ie}, ctl ? "R1/R3 flags" : "R1 ordinary flags", 32'(flags), 32'({take, keep && ie}));
    @(negedge clk);
    chk(pause_req == 1'b0, "R4 single-cycle pulse", 32'(pause_req), 32'h0);
    repeat (3) @(negedge clk);
    chk(flags == {take, keep && ie}, "R8 sticky", 32'(flags), 32'({take, keep && ie}));
    chk(irq_out == (take || (keep && ie)), "R8 irq_out", 32'(irq_out), 32'(take || (keep && ie)));
    irq_clear = 2'b01;
    @(negedge clk);
    irq_clear = 2'b00;
    chk(flags[0] == 1'b0 && flags[1] == take, "R8 clear bit0 only", 32'(flags), 32'({take, 1'b0}));
    irq_clear = 2'b10;
    @(negedge clk);
    irq_clear = 2'b00;
    chk(flags == 2'b00 && !irq_out, "R8 clear", 32'(flags), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pause_req == 0 && desc_wr == 0 && desc_out == 0 && flags == 0 && irq_out == 0,
        "R9 reset", {flags, desc_wr, pause_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // exact 64-byte PAUSE frame with both modes set pass_all then rx_flow
    pass_all = 1'b1; rx_flow = 1'b0;
    run_frame(0, 1'b1, 64, 16'h0010, 1'b1);
    chk(1'b1, "R6 0x00406100 case covered above", 32'h0, 32'h0);
    for (int m = 0; m < 4; m++) begin
      pass_all = m[0]; rx_flow = m[1];
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < 2; c++)
          run_frame(k, c[0], (k == 2) ? 64 + 7 * c : 64, 16'(16'h1000 * m + 16 * k + c + 5), ((k + c + m) % 2) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule